// File: doc/BRIEF.md
# Unlock Sequence Command Decoder

This block sits on the write side of a two-bank, word-wide flash memory model and turns bus write cycles into array commands. Each write cycle is a single-clock strobe `wr_valid` with a 19-bit address and a 16-bit data word. The decoder follows the three-write unlock pattern, which leads to program, ID-mode entry or ID-mode exit, and the six-write pattern, which leads to sector, block or whole-bank erase. When a pattern completes, it raises a one-clock command pulse. The pulse carries the command kind, the target bank, the offset address and the data word of the final write.

Only address bits 14..0 and data bits 7..0 take part in the key comparisons. Bit 18 of the final write picks the bank. Bits 17..0 of the final write give the word address for program, the sector field (17..10) for sector erase and the block field (17..15) for block erase. While the array engine reports `busy`, every write is dropped and the position reached in the sequence is kept. The command output has no back-pressure: the pulse lasts exactly one cycle and the consumer must accept it in that cycle. Write strobes are never stalled.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset `cmd_valid` is low and no command is pending.
- R2: The writes 0xAA at key address 0x5555, then 0x55 at 0x2AAA, then a third write at 0x5555 with code 0x90 produce an ID-entry pulse (kind 4). With code 0xF0 the same sequence produces an ID-exit pulse (kind 5). Any other code at step three aborts the sequence without a pulse, except 0xA0 and 0x80, which continue it.
- R3: After the third-write code 0xA0, the next write at any address produces a program pulse (kind 0). `cmd_addr` equals bits 17..0 of that write and `cmd_data` equals its full 16-bit data.
- R4: After third-write code 0x80, writes four and five must be 0xAA at 0x5555 and 0x55 at 0x2AAA. The sixth write then selects the erase:
  - 0x30 at any address gives a sector erase (kind 1).
  - 0x50 at any address gives a block erase (kind 2).
  - 0x10 at 0x5555 gives a bank erase (kind 3).
  - Anything else gives no pulse.
  For erase pulses, `cmd_addr` is bits 17..0 of the sixth write.
- R5: During command writes, address bits 17..15 and data bits 15..8 are ignored. A difference in address bits 14..0 or in data bits 7..0 from the expected key does break the match.
- R6: `cmd_bank` is bit 18 of the final write of the sequence, whatever bit 18 was in the earlier writes.
- R7: A write that does not fit the current step returns the decoder to idle and is discarded. Even if that write is 0xAA at 0x5555, it does not begin a new sequence.
- R8: A write presented while `busy` is high has no effect. It produces no pulse and leaves the sequence position unchanged.
- R9: Cycles without a write strobe, however many, leave the sequence position unchanged.
- R10: Each command appears as a single-cycle `cmd_valid` pulse in the cycle after the clock edge that captured the final write. `cmd_kind`, `cmd_bank`, `cmd_addr` and `cmd_data` are valid with it. The kinds are encoded 0 program, 1 sector, 2 block, 3 bank, 4 ID entry, 5 ID exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_addr | input | 19 | Write address; bit 18 is the bank |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Array engine busy; writes are dropped |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_kind | output | 3 | Command kind (encoding in R10) |
| cmd_bank | output | 1 | Target bank |
| cmd_addr | output | 18 | Offset address of the final write |
| cmd_data | output | 16 | Data of the final write |

## Verification
Every one of the 256 third-write codes is swept, which separates the two ID codes, the program and erase continuations and the codes that must abort. Every one of the 256 sixth-write codes is swept both at the key address and at a scattered address, which separates the sector, block and bank erase decodes and shows that bank erase alone depends on the address. Each of the six erase steps is corrupted in turn, once in data and once in address, and the remaining steps are then replayed to show the decoder aborts at every position. Separate patterns set the ignored high bits, flip the bank bit between writes, insert busy and idle cycles mid-sequence and present a key write as the aborting write, which distinguishes "ignored" from "reset" and "restart".

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  typedef enum logic [2:0] {
    CMD_PROGRAM  = 3'd0,
    CMD_SECTOR   = 3'd1,
    CMD_BLOCK    = 3'd2,
    CMD_BANK     = 3'd3,
    CMD_ID_ENTER = 3'd4,
    CMD_ID_EXIT  = 3'd5
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROG,
    ST_ERS3,
    ST_ERS4,
    ST_ERS5
  } seq_state_e;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_PROG   = 8'hA0;
  localparam logic [CODE_W-1:0] CODE_IDIN   = 8'h90;
  localparam logic [CODE_W-1:0] CODE_IDOUT  = 8'hF0;
  localparam logic [CODE_W-1:0] CODE_ERASE  = 8'h80;
  localparam logic [CODE_W-1:0] CODE_SECTOR = 8'h30;
  localparam logic [CODE_W-1:0] CODE_BLOCK  = 8'h50;
  localparam logic [CODE_W-1:0] CODE_BANK   = 8'h10;
  localparam logic [CODE_W-1:0] BYTE_FIRST  = 8'hAA;
  localparam logic [CODE_W-1:0] BYTE_SECOND = 8'h55;

endpackage

// File: rtl/ucd_match.sv
module ucd_match #(
  parameter int KEY_W = 15,
  parameter int CODE_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = 15'h5555,
  parameter logic [KEY_W-1:0] KEY_B = 15'h2AAA,
  parameter logic [CODE_W-1:0] BYTE_A = 8'hAA,
  parameter logic [CODE_W-1:0] BYTE_B = 8'h55
) (
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [CODE_W-1:0] key_code,
  output logic              hit_first,
  output logic              hit_second,
  output logic              at_first
);

  assign at_first   = (key_addr == KEY_A);
  assign hit_first  = at_first && (key_code == BYTE_A);
  assign hit_second = (key_addr == KEY_B) && (key_code == BYTE_B);

endmodule

// File: rtl/ucd_seq.sv
module ucd_seq
  import ucd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              hit_first,
  input  logic              hit_second,
  input  logic              at_first,
  input  logic [CODE_W-1:0] code,
  output logic              emit,
  output cmd_kind_e         kind
);

  seq_state_e state, nxt;

  always_comb begin
    nxt  = state;
    emit = 1'b0;
    kind = CMD_PROGRAM;
    if (step) begin
      nxt = ST_IDLE;
      case (state)
        ST_IDLE: if (hit_first)  nxt = ST_KEY1;
        ST_KEY1: if (hit_second) nxt = ST_KEY2;
        ST_KEY2: begin
          if (at_first) begin
            case (code)
              CODE_PROG:  nxt = ST_PROG;
              CODE_ERASE: nxt = ST_ERS3;
              CODE_IDIN:  begin emit = 1'b1; kind = CMD_ID_ENTER; end
              CODE_IDOUT: begin emit = 1'b1; kind = CMD_ID_EXIT;  end
              default:    nxt = ST_IDLE;
            endcase
          end
        end
        ST_PROG: begin
          emit = 1'b1;
          kind = CMD_PROGRAM;
        end
        ST_ERS3: if (hit_first)  nxt = ST_ERS4;
        ST_ERS4: if (hit_second) nxt = ST_ERS5;
        ST_ERS5: begin
          if (code == CODE_SECTOR) begin
            emit = 1'b1; kind = CMD_SECTOR;
          end else if (code == CODE_BLOCK) begin
            emit = 1'b1; kind = CMD_BLOCK;
          end else if (code == CODE_BANK && at_first) begin
            emit = 1'b1; kind = CMD_BANK;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/ucd_out.sv
module ucd_out #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int KIND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [KIND_W-1:0] kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid,
  output logic [KIND_W-1:0] kind,
  output logic              bank,
  output logic [ADDR_W-2:0] offset,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      kind   <= '0;
      bank   <= 1'b0;
      offset <= '0;
      data   <= '0;
    end else begin
      valid <= load;
      if (load) begin
        kind   <= kind_in;
        bank   <= addr_in[ADDR_W-1];
        offset <= addr_in[ADDR_W-2:0];
        data   <= data_in;
      end
    end
  end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int KEY_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic              cmd_bank,
  output logic [ADDR_W-2:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int KIND_W = $bits(cmd_kind_e);

  logic      step;
  logic      hit_first, hit_second, at_first;
  logic      emit;
  cmd_kind_e kind_w;

  assign step = wr_valid && !busy;

  ucd_match #(
    .KEY_W (KEY_W),
    .CODE_W(CODE_W),
    .KEY_A (KEY_W'(15'h5555)),
    .KEY_B (KEY_W'(15'h2AAA)),
    .BYTE_A(BYTE_FIRST),
    .BYTE_B(BYTE_SECOND)
  ) u_match (
    .key_addr  (wr_addr[KEY_W-1:0]),
    .key_code  (wr_data[CODE_W-1:0]),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .at_first  (at_first)
  );

  ucd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .at_first  (at_first),
    .code      (wr_data[CODE_W-1:0]),
    .emit      (emit),
    .kind      (kind_w)
  );

  ucd_out #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .KIND_W(KIND_W)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (emit),
    .kind_in(kind_w),
    .addr_in(wr_addr),
    .data_in(wr_data),
    .valid  (cmd_valid),
    .kind   (cmd_kind),
    .bank   (cmd_bank),
    .offset (cmd_addr),
    .data   (cmd_data)
  );

endmodule

// File: rtl/ucd_checker.sv
module ucd_checker #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic              cmd_bank,
  input logic [ADDR_W-2:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data
);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R10

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_kind <= 3'd5); // R10

  AST_NEEDS_LIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_valid && !busy)); // R8

  AST_BANK_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_bank == $past(wr_addr[ADDR_W-1])); // R6

  AST_ADDR_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr == $past(wr_addr[ADDR_W-2:0])); // R3

  AST_PROG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd0) |-> cmd_data == $past(wr_data)); // R3

  AST_BANK_ERASE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd3) |->
      ($past(wr_addr[14:0]) == 15'h5555 && $past(wr_data[7:0]) == 8'h10)); // R4

  AST_SECTOR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd1) |-> $past(wr_data[7:0]) == 8'h30); // R4

endmodule

bind unlock_cmd_decoder ucd_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .busy     (busy),
  .cmd_valid(cmd_valid),
  .cmd_kind (cmd_kind),
  .cmd_bank (cmd_bank),
  .cmd_addr (cmd_addr),
  .cmd_data (cmd_data)
);

// File: tb/test_unlock_cmd_decoder.sv
module test_unlock_cmd_decoder;

  localparam logic [2:0] K_PROG = 3'd0, K_SECT = 3'd1, K_BLK = 3'd2,
                         K_BANK = 3'd3, K_IDIN = 3'd4, K_IDOUT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        cmd_valid;
  logic [2:0]  cmd_kind;
  logic        cmd_bank;
  logic [17:0] cmd_addr;
  logic [15:0] cmd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] salt = 8'h00;

  logic        obs_v;
  logic [2:0]  obs_k;
  logic        obs_b;
  logic [17:0] obs_a;
  logic [15:0] obs_d;

  always #5 clk = ~clk;

  unlock_cmd_decoder i_unlock_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  function automatic logic [18:0] mk(input logic bk, input logic [2:0] up,
                                     input logic [14:0] low);
    return {bk, up, low};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
    wr_addr = {salt[0], salt[7:0], salt[7:0], salt[1:0]};
    wr_data = {salt, ~salt};
    obs_v = cmd_valid; obs_k = cmd_kind; obs_b = cmd_bank;
    obs_a = cmd_addr;  obs_d = cmd_data;
  endtask

  task automatic seq(input string req, input logic [18:0] a, input logic [15:0] d,
                     input logic b, input bit ev, input logic [2:0] k);
    logic [38:0] act, exp;
    wr(a, d, b);
    act = obs_v ? {1'b1, obs_k, obs_b, obs_a, obs_d} : 39'd0;
    exp = ev ? {1'b1, k, a[18], a[17:0], d} : 39'd0;
    check(act == exp, req, 64'(act), 64'(exp));
    if (obs_v) begin
      @(negedge clk);
      check(!cmd_valid, "R10", 64'(cmd_valid), 64'd0);
    end
  endtask

  task automatic prefix(input logic bk, input string req);
    salt = salt + 8'd1;
    seq(req, mk(bk, salt[2:0], 15'h5555), {salt, 8'hAA}, 1'b0, 0, 3'd0);
    seq(req, mk(~bk, salt[5:3], 15'h2AAA), {~salt, 8'h55}, 1'b0, 0, 3'd0);
  endtask

  function automatic logic [18:0] ers_addr(input int k);
    return (k == 1 || k == 4) ? 19'h02AAA : 19'h05555;
  endfunction

  function automatic logic [15:0] ers_data(input int k);
    case (k)
      0, 3:    return 16'h00AA;
      1, 4:    return 16'h0055;
      2:       return 16'h0080;
      default: return 16'h0010;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic        bk;
    logic [7:0]  cc;
    logic        ev;
    logic [2:0]  ek;
    logic [18:0] fa;

    repeat (3) @(negedge clk);
    check(!cmd_valid, "R1", 64'(cmd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid, "R1", 64'(cmd_valid), 64'd0);

    // R2 / R3: sweep every third-write code
    for (int c = 0; c < 256; c++) begin
      cc = c[7:0]; bk = c[0];
      prefix(~bk, "R2");
      ev = (cc == 8'h90) || (cc == 8'hF0);
      ek = (cc == 8'h90) ? K_IDIN : K_IDOUT;
      seq("R2", mk(bk, cc[2:0], 15'h5555), {~cc, cc}, 1'b0, ev, ek);
      if (cc == 8'hA0) begin
        seq("R3", {bk, 18'(c * 1031 + 7)}, 16'hC3A5, 1'b0, 1, K_PROG);
      end else if (cc == 8'h80) begin
        prefix(~bk, "R4");
        seq("R4", mk(bk, 3'd5, 15'h5555), 16'hEE10, 1'b0, 1, K_BANK);
      end
    end

    // R4: sweep every sixth-write code, at the key address and elsewhere
    for (int c = 0; c < 256; c++) begin
      for (int at = 0; at < 2; at++) begin
        cc = c[7:0]; bk = c[1];
        prefix(~bk, "R4");
        seq("R4", mk(~bk, 3'd2, 15'h5555), 16'h0080, 1'b0, 0, 3'd0);
        prefix(~bk, "R4");
        fa = (at == 1) ? mk(bk, cc[2:0], 15'h5555) : {bk, cc, 10'(c * 37 + 5)};
        ev = 1'b1; ek = K_SECT;
        if (cc == 8'h30)      ek = K_SECT;
        else if (cc == 8'h50) ek = K_BLK;
        else if (cc == 8'h10 && fa[14:0] == 15'h5555) ek = K_BANK;
        else ev = 1'b0;
        seq("R4", fa, {cc ^ 8'h5A, cc}, 1'b0, ev, ek);
      end
    end

    // R7: corrupt each erase step in data, then in address, replay the rest
    for (int k = 0; k < 6; k++) begin
      for (int v = 0; v < 2; v++) begin
        for (int s = 0; s < 6; s++) begin
          if (s == k)
            seq("R7", ers_addr(s) ^ ((v == 1) ? 19'h00001 : 19'h0),
                ers_data(s) ^ ((v == 0) ? 16'h0001 : 16'h0), 1'b0, 0, 3'd0);
          else
            seq("R7", ers_addr(s), ers_data(s), 1'b0, 0, 3'd0);
        end
      end
    end

    // R7: an aborting write that equals the first key does not restart
    prefix(1'b0, "R7");
    seq("R7", 19'h05555, 16'h00AA, 1'b0, 0, 3'd0);
    seq("R7", 19'h02AAA, 16'h0055, 1'b0, 0, 3'd0);
    seq("R7", 19'h45555, 16'h0090, 1'b0, 0, 3'd0);
    prefix(1'b0, "R7");
    seq("R7", 19'h45555, 16'h0090, 1'b0, 1, K_IDIN);

    // R5: high address and data bits set in every command write
    seq("R5", 19'h3D555, 16'hFFAA, 1'b0, 0, 3'd0);
    seq("R5", 19'h3AAAA, 16'hFF55, 1'b0, 0, 3'd0);
    seq("R5", 19'h3D555, 16'hFFF0, 1'b0, 1, K_IDOUT);
    // R5: a difference in bit 14 breaks the match
    seq("R5", 19'h01555, 16'h00AA, 1'b0, 0, 3'd0);
    seq("R5", 19'h02AAA, 16'h0055, 1'b0, 0, 3'd0);
    seq("R5", 19'h05555, 16'h0090, 1'b0, 0, 3'd0);

    // R6: bank only from the final write
    seq("R6", 19'h45555, 16'h00AA, 1'b0, 0, 3'd0);
    seq("R6", 19'h42AAA, 16'h0055, 1'b0, 0, 3'd0);
    seq("R6", 19'h45555, 16'h00A0, 1'b0, 0, 3'd0);
    seq("R6", 19'h01234, 16'hBEEF, 1'b0, 1, K_PROG);

    // R8: busy write mid-sequence is ignored and position kept
    prefix(1'b1, "R8");
    seq("R8", 19'h01234, 16'h1234, 1'b1, 0, 3'd0);
    seq("R8", 19'h05555, 16'h0090, 1'b1, 0, 3'd0);
    seq("R8", 19'h05555, 16'h0090, 1'b0, 1, K_IDIN);
    // R8: a whole sequence under busy produces nothing and leaves idle
    seq("R8", 19'h05555, 16'h00AA, 1'b1, 0, 3'd0);
    seq("R8", 19'h02AAA, 16'h0055, 1'b1, 0, 3'd0);
    seq("R8", 19'h05555, 16'h00F0, 1'b1, 0, 3'd0);
    seq("R8", 19'h05555, 16'h00F0, 1'b0, 0, 3'd0);

    // R9: idle cycles between writes keep the position
    seq("R9", 19'h05555, 16'h00AA, 1'b0, 0, 3'd0);
    repeat (7) @(negedge clk);
    seq("R9", 19'h02AAA, 16'h0055, 1'b0, 0, 3'd0);
    repeat (5) @(negedge clk);
    seq("R9", 19'h45555, 16'h00A0, 1'b0, 0, 3'd0);
    repeat (9) @(negedge clk);
    seq("R9", 19'h7FFFF, 16'h0000, 1'b0, 1, K_PROG);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule